// File: doc/BRIEF.md
# Asynchronous Host Register Port with Digital I/O

This block is the slave end of an asynchronous microprocessor bus. A host addresses one of sixteen 12-bit register locations through a 4-bit address. It qualifies the access with active-low chip-select, read and write strobes, and moves data over a shared bidirectional 12-bit bus. Reads are combinational: while chip select and read are both low, the addressed register drives the bus. Writes are captured on the rising edge of the write strobe. The strobes are first brought into the core clock domain by two-flop synchronisers. A small state machine then follows each bus cycle through the states `ST_IDLE`, `ST_WR_LOW`, `ST_WR_COMMIT` and `ST_RD_LOW`.

Transitions: `ST_IDLE` goes to `ST_WR_LOW` when synchronised chip select and write are both low. Otherwise it goes to `ST_RD_LOW` when chip select and read are both low. `ST_WR_LOW` goes to `ST_WR_COMMIT` when the synchronised write strobe rises, and address and data are captured on that transition. `ST_WR_COMMIT` writes the register and returns to `ST_IDLE` after one cycle. `ST_RD_LOW` returns to `ST_IDLE` when read or chip select goes high. Entering `ST_RD_LOW` at address 0 clears the pending I/O interrupt.

The block holds a digital I/O port with a data register and a control register. The port raises an active-low interrupt request when an enabled input pin changes. It also offers read/write ports whose contents are driven out to neighbouring logic, and read-only ports that return status words from neighbouring converters.

Top module: `hostbus_regport`

## Requirements
- R1: After reset, every I/O pin is an input, all pin interrupt enables are 0, the pin outputs are 0, `irq_n` is 1, and all read/write ports hold 0.
- R2: The block drives `host_data` only while `host_cs_n` and `host_rd_n` are both 0. Otherwise the bus carries whatever another driver places on it.
- R3: A write stores `host_data` into the location given by `host_addr` once `host_wr_n` rises with `host_cs_n` low. The new value appears at the outputs on the fourth core clock edge after the rise: two synchroniser stages, one detect edge, one commit edge. It is not visible earlier.
- R4: A write strobe pulsed while `host_cs_n` is 1 changes no register.
- R5: Address 0 is the I/O data register. Writing it sets `gpio_out` from bits [IO_W-1:0]. Reading it returns, for each bit, the synchronised pin level if the pin is an input, or the stored output value if the pin is an output.
- R6: Address 1 is the I/O control register. Bits [IO_W-1:0] give each pin's direction (1 = output, 0 = input) and appear on `gpio_oe`. Bits [2*IO_W-1:IO_W] are the per-pin interrupt enables. Upper bits read 0.
- R7: A level change on a pin that is an input and has its interrupt enable at 1 sets a sticky flag and drives `irq_n` to 0. Changes on output pins or on disabled pins leave `irq_n` at 1.
- R8: A read of address 0 clears the flag, so `irq_n` returns to 1 while the read is still in progress.
- R9: Addresses 4 to 7 are read/write ports. Each reads back its stored value and drives its slice of `ctl_regs`, with address 4 in bits [11:0].
- R10: Addresses 8 to 11 are read-only ports. Each returns its 12-bit slice of `stat_regs`, with address 8 in bits [11:0], and bit 0 always reads 0.
- R11: Addresses 2, 3 and 12 to 15 are reserved. They read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low; data taken on rising edge |
| host_addr | input | 4 | Register address |
| host_data | inout | 12 | Bidirectional data bus |
| gpio_in | input | 6 | Pin levels from the pads |
| gpio_out | output | 6 | Pin output values |
| gpio_oe | output | 6 | Pin output enables (1 = output) |
| irq_n | output | 1 | Interrupt request, active low |
| ctl_regs | output | 48 | Read/write port contents, four 12-bit words |
| stat_regs | input | 48 | Read-only status words, four 12-bit words |

## Verification
The assertions check four properties on every cycle. A commit is always preceded by the write-low state. The control register and all visible registers stay unchanged unless a matching write commits. The interrupt request stays low until a clear arrives. Read-only ports never return a set bit 0. Only the bench scenarios can show the cycle at which a write becomes visible, the rejection of strobes without chip select, the bus release, and the interrupt differences between input and output pins and between enabled and disabled pins.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_LOW,
        ST_WR_COMMIT,
        ST_RD_LOW
    } bus_state_e;

    localparam logic [ADDR_W-1:0] A_IO_DATA = 4'd0;
    localparam logic [ADDR_W-1:0] A_IO_CTRL = 4'd1;
    localparam logic [ADDR_W-1:0] A_RW_BASE = 4'd4;
    localparam logic [ADDR_W-1:0] A_RO_BASE = 4'd8;
endpackage

// File: rtl/hostbus_sync.sv
module hostbus_sync #(
    parameter int         W       = 1,
    parameter logic       RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= {W{RST_VAL}};
            q      <= {W{RST_VAL}};
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hostbus_ctrl.sv
module hostbus_ctrl
    import hostbus_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s_n,
    input  logic              rd_s_n,
    input  logic              wr_s_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic              rd_clr
);
    bus_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!cs_s_n && !wr_s_n)      state_nx = ST_WR_LOW;
                else if (!cs_s_n && !rd_s_n) state_nx = ST_RD_LOW;
            end
            ST_WR_LOW:    if (wr_s_n) state_nx = ST_WR_COMMIT;
            ST_WR_COMMIT: state_nx = ST_IDLE;
            ST_RD_LOW:    if (rd_s_n || cs_s_n) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // capture of address and data on the detected rising write edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (state == ST_WR_LOW && state_nx == ST_WR_COMMIT) begin
            wr_addr <= addr;
            wr_data <= data;
        end
    end

    // outputs
    always_comb begin
        wr_en  = (state == ST_WR_COMMIT);
        rd_clr = (state == ST_IDLE) && (state_nx == ST_RD_LOW) && (addr == A_IO_DATA);
    end

    assert_commit_after_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_COMMIT) |-> ($past(state) == ST_WR_LOW));
endmodule

// File: rtl/hostbus_gpio.sv
module hostbus_gpio #(
    parameter int DW   = 12,
    parameter int IO_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IO_W-1:0] pin_in,
    input  logic            wr_data_sel,
    input  logic            wr_ctrl_sel,
    input  logic [2*IO_W-1:0] wr_val,
    input  logic            clr,
    output logic [IO_W-1:0] pin_out,
    output logic [IO_W-1:0] pin_oe,
    output logic [DW-1:0]   data_rd,
    output logic [DW-1:0]   ctrl_rd,
    output logic            irq_n
);
    localparam int CW = 2 * IO_W;

    logic [CW-1:0]   ctrl_q;
    logic [IO_W-1:0] out_q, pin_s, pin_prev, ie, chg, rd_mix;
    logic            flag_q;

    hostbus_sync #(.W(IO_W), .RST_VAL(1'b0)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
    );

    assign pin_oe = ctrl_q[IO_W-1:0];
    assign ie     = ctrl_q[CW-1:IO_W];
    assign chg    = (pin_s ^ pin_prev) & ~pin_oe & ie;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            out_q    <= '0;
            pin_prev <= '0;
            flag_q   <= 1'b0;
        end else begin
            pin_prev <= pin_s;
            if (wr_ctrl_sel) ctrl_q <= wr_val;
            if (wr_data_sel) out_q  <= wr_val[IO_W-1:0];
            if (|chg)        flag_q <= 1'b1;
            else if (clr)    flag_q <= 1'b0;
        end
    end

    for (genvar b = 0; b < IO_W; b++) begin : g_mix
        assign rd_mix[b] = pin_oe[b] ? out_q[b] : pin_s[b];
    end

    assign pin_out = out_q;
    assign data_rd = DW'(rd_mix);
    assign ctrl_rd = DW'(ctrl_q);
    assign irq_n   = ~flag_q;

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !clr) |=> !irq_n);
    assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl_sel |=> $stable(pin_oe));
endmodule

// File: rtl/hostbus_regport.sv
module hostbus_regport
    import hostbus_pkg::*;
#(
    parameter int DW   = 12,
    parameter int IO_W = 6,
    parameter int N_RW = 4,
    parameter int N_RO = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_cs_n,
    input  logic               host_rd_n,
    input  logic               host_wr_n,
    input  logic [ADDR_W-1:0]  host_addr,
    inout  wire  [DW-1:0]      host_data,
    input  logic [IO_W-1:0]    gpio_in,
    output logic [IO_W-1:0]    gpio_out,
    output logic [IO_W-1:0]    gpio_oe,
    output logic               irq_n,
    output logic [N_RW*DW-1:0] ctl_regs,
    input  logic [N_RO*DW-1:0] stat_regs
);
    localparam int CW = 2 * IO_W;

    logic [2:0]        strobes_s;
    logic              wr_en, rd_clr;
    logic [ADDR_W-1:0] wr_addr;
    logic [DW-1:0]     wr_data, rdata, io_data_rd, io_ctrl_rd;
    logic [DW-1:0]     rw_q [N_RW];

    hostbus_sync #(.W(3), .RST_VAL(1'b1)) u_strobe_sync (
        .clk(clk), .rst_n(rst_n),
        .d({host_cs_n, host_rd_n, host_wr_n}),
        .q(strobes_s)
    );

    hostbus_ctrl #(.DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cs_s_n(strobes_s[2]), .rd_s_n(strobes_s[1]), .wr_s_n(strobes_s[0]),
        .addr(host_addr), .data(host_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_clr(rd_clr)
    );

    hostbus_gpio #(.DW(DW), .IO_W(IO_W)) u_gpio (
        .clk(clk), .rst_n(rst_n), .pin_in(gpio_in),
        .wr_data_sel(wr_en && wr_addr == A_IO_DATA),
        .wr_ctrl_sel(wr_en && wr_addr == A_IO_CTRL),
        .wr_val(wr_data[CW-1:0]), .clr(rd_clr),
        .pin_out(gpio_out), .pin_oe(gpio_oe),
        .data_rd(io_data_rd), .ctrl_rd(io_ctrl_rd), .irq_n(irq_n)
    );

    for (genvar g = 0; g < N_RW; g++) begin : g_rw
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rw_q[g] <= '0;
            else if (wr_en && wr_addr == A_RW_BASE + ADDR_W'(g))
                rw_q[g] <= wr_data;
        end
        assign ctl_regs[g*DW +: DW] = rw_q[g];
    end

    always_comb begin
        rdata = '0;
        if (host_addr == A_IO_DATA) rdata = io_data_rd;
        if (host_addr == A_IO_CTRL) rdata = io_ctrl_rd;
        for (int i = 0; i < N_RW; i++)
            if (host_addr == A_RW_BASE + ADDR_W'(i)) rdata = rw_q[i];
        for (int i = 0; i < N_RO; i++)
            if (host_addr == A_RO_BASE + ADDR_W'(i))
                rdata = stat_regs[i*DW +: DW] & ~DW'(1);
    end

    assign host_data = (!host_cs_n && !host_rd_n) ? rdata : {DW{1'bz}};

    function automatic logic is_resv(input logic [ADDR_W-1:0] a);
        return (a != A_IO_DATA) && (a != A_IO_CTRL)
            && !(a >= A_RW_BASE && a < A_RW_BASE + ADDR_W'(N_RW))
            && !(a >= A_RO_BASE && a < A_RO_BASE + ADDR_W'(N_RO));
    endfunction

    assert_resv_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_resv(wr_addr)) |=> ($stable(ctl_regs) && $stable(gpio_out) && $stable(gpio_oe)));
    assert_ro_lsb_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_cs_n && !host_rd_n && host_addr >= A_RO_BASE
         && host_addr < A_RO_BASE + ADDR_W'(N_RO)) |-> (host_data[0] == 1'b0));
    assert_rw_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_regs));
endmodule

// File: tb/test_hostbus_regport.sv
module test_hostbus_regport;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [3:0]  host_addr = '0;
    wire  [11:0] host_data;
    logic [11:0] drv_val = '0;
    logic        drv_en = 1'b0;
    logic [5:0]  gpio_in = '0;
    logic [5:0]  gpio_out, gpio_oe;
    logic        irq_n;
    logic [47:0] ctl_regs;
    logic [47:0] stat_regs = '0;

    assign host_data = drv_en ? drv_val : 12'bz;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostbus_regport i_hostbus_regport (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
        .host_wr_n(host_wr_n), .host_addr(host_addr), .host_data(host_data),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq_n(irq_n),
        .ctl_regs(ctl_regs), .stat_regs(stat_regs)
    );

    typedef struct { string tag; int unsigned exp; } exp_t;
    exp_t        exp_q[$];
    int unsigned act_q[$];
    event        obs_ev;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    // driver side: push expectation and observed value
    task automatic expect_val(input string tag, input int unsigned act, input int unsigned exp);
        exp_q.push_back('{tag, exp});
        act_q.push_back(act);
        ->obs_ev;
    endtask

    // monitor: pop and compare
    initial forever begin
        @(obs_ev);
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            exp_t e;
            int unsigned a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            checks++;
            if (a != e.exp) begin
                errors++;
                $display("FAIL %s actual=0x%0h expected=0x%0h", e.tag, a, e.exp);
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [11:0] v, input bit sel);
        @(negedge clk);
        host_addr = a; drv_val = v; drv_en = 1'b1;
        host_cs_n = ~sel; host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (5) @(negedge clk);
        host_cs_n = 1'b1; drv_en = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [11:0] v);
        @(negedge clk);
        host_addr = a; host_cs_n = 1'b0; host_rd_n = 1'b0;
        repeat (5) @(negedge clk);
        v = host_data;
        host_rd_n = 1'b1; host_cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        expect_val("R1 irq_n", irq_n, 1);
        expect_val("R1 gpio_oe", gpio_oe, 0);
        expect_val("R1 gpio_out", gpio_out, 0);
        expect_val("R1 ctl_regs", ctl_regs[31:0], 0);
        bus_read(4'd1, v);
        expect_val("R1 ctrl read", v, 0);

        // R9 read/write ports
        bus_write(4'd4, 12'h123, 1'b1);
        bus_read(4'd4, v);
        expect_val("R9 addr4 readback", v, 12'h123);
        expect_val("R9 ctl slot0", ctl_regs[11:0], 12'h123);
        bus_write(4'd7, 12'hABC, 1'b1);
        expect_val("R9 ctl slot3", ctl_regs[47:36], 12'hABC);

        // R3 write timing
        @(negedge clk);
        host_addr = 4'd5; drv_val = 12'h055; drv_en = 1'b1;
        host_cs_n = 1'b0; host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (3) @(negedge clk);
        expect_val("R3 not yet visible", ctl_regs[23:12], 12'h000);
        @(negedge clk);
        expect_val("R3 visible after commit", ctl_regs[23:12], 12'h055);
        repeat (2) @(negedge clk);
        host_cs_n = 1'b1; drv_en = 1'b0;
        repeat (2) @(negedge clk);

        // R4 write without chip select
        bus_write(4'd4, 12'hFFF, 1'b0);
        expect_val("R4 cs high ignored", ctl_regs[11:0], 12'h123);

        // R2 bus release
        @(negedge clk);
        host_addr = 4'd4; host_cs_n = 1'b1; host_rd_n = 1'b0;
        drv_val = 12'h3C3; drv_en = 1'b1;
        repeat (2) @(negedge clk);
        expect_val("R2 cs high no drive", host_data, 12'h3C3);
        host_rd_n = 1'b1; host_cs_n = 1'b0; drv_val = 12'h5A5;
        repeat (2) @(negedge clk);
        expect_val("R2 rd high no drive", host_data, 12'h5A5);
        host_cs_n = 1'b1; drv_en = 1'b0;
        repeat (3) @(negedge clk);

        // R11 reserved
        bus_write(4'd2, 12'h777, 1'b1);
        bus_read(4'd2, v);
        expect_val("R11 addr2 reads zero", v, 0);
        bus_read(4'd13, v);
        expect_val("R11 addr13 reads zero", v, 0);
        expect_val("R11 no side effect", ctl_regs[11:0], 12'h123);

        // R10 read-only ports
        stat_regs[11:0]  = 12'h7FF;
        stat_regs[47:36] = 12'h801;
        bus_read(4'd8, v);
        expect_val("R10 addr8", v, 12'h7FE);
        bus_read(4'd11, v);
        expect_val("R10 addr11", v, 12'h800);

        // R6 control: pins 0-3 output, interrupts enabled on pins 4,5
        bus_write(4'd1, 12'hC0F, 1'b1);
        expect_val("R6 gpio_oe", gpio_oe, 6'h0F);
        bus_read(4'd1, v);
        expect_val("R6 ctrl readback", v, 12'hC0F);

        // R5 data register
        bus_write(4'd0, 12'h02A, 1'b1);
        expect_val("R5 gpio_out", gpio_out, 6'h2A);
        bus_read(4'd0, v);
        expect_val("R5 mixed readback", v, 12'h00A);

        // R7 output pin change ignored
        gpio_in = 6'b000100;
        repeat (6) @(negedge clk);
        expect_val("R7 output pin no irq", irq_n, 1);

        // R7 enabled input change
        gpio_in = 6'b100100;
        repeat (5) @(negedge clk);
        expect_val("R7 irq asserted", irq_n, 0);
        repeat (5) @(negedge clk);
        expect_val("R7 irq sticky", irq_n, 0);

        // R8 read clears
        bus_read(4'd0, v);
        expect_val("R5 input bit readback", v, 12'h02A);
        expect_val("R8 irq released", irq_n, 1);

        // R7 disabled input change ignored
        bus_write(4'd1, 12'h80F, 1'b1);
        gpio_in = 6'b110100;
        repeat (6) @(negedge clk);
        expect_val("R7 disabled pin no irq", irq_n, 1);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule